// File: doc/BRIEF.md
# PCI Host Bridge Register Block

This block is the register face of an on-chip PCI host controller. A processor reaches it over a simple 32-bit register bus that uses a valid/ready handshake. The block holds the controller's own 256-byte configuration header. It also holds three base and address registers: one selects the configuration target, one sets the memory base, and one places the I/O window.

A data-port offset forwards processor reads and writes as 32-bit configuration requests on a downstream request/acknowledge interface. Each request targets the address held in the configuration address register.

A combinational decoder tells the system fabric whether a processor address falls in the 256 KiB I/O window. A small router merges per-slot interrupt lines onto four interrupt outputs.

Top module: `pcib_regs`

## Requirements
- R1: Byte offsets 0x004 to 0x0FC hold local header words. Each is written and read as one 32-bit word, and byte 0 of the word is the lowest-addressed header byte.
- R2: The word at offset 0x000 always reads {DEVICE_ID[15:0], VENDOR_ID[15:0]} (defaults 0x3C4D and 0x1A2B). Writes to it are discarded.
- R3: After reset, the word at 0x004 reads 0x0290_0080. The command half has bit 7 (wait cycles) set. The status half has bit 4 (capability list), bit 7 (fast back-to-back) and bits 10:9 = 01 (medium select timing) set. All other header words read zero.
- R4: Offset 0x1C0 is the configuration address register. It resets to zero, keeps every bit written, and reads back exactly.
- R5: Offset 0x1C4 is the memory base register. It resets to zero, keeps only bits 31:24 and bit 0 of a write, and reads zero elsewhere.
- R6: Offset 0x1C8 is the I/O base register. It resets to 0xFE24_0000 and keeps bits 31:18 and bit 0. A write whose bits 31:18 equal the stored bits 31:18 is ignored entirely, bit 0 included.
- R7: `io_hit` is high in the same cycle when `cpu_addr[31:18]` equals the I/O base bits 31:18. This selects a 0x40000-byte window.
- R8: A read at offset 0x220 raises `cfg_valid` with `cfg_write`=0 and `cfg_addr` equal to the configuration address register. `bus_ready` stays low until `cfg_ack`. The read returns the `cfg_rdata` captured at the acknowledge, and `bus_ready` rises one cycle after the acknowledge.
- R9: A write at offset 0x220 issues `cfg_write`=1 with `cfg_wdata` equal to the bus write data, addressed as in R8. It completes the same way.
- R10: Reads of unmapped offsets (0x100 to 0x1BC, 0x1CC to 0x21C, above 0x220) return zero. Writes to them change no register.
- R11: An access with `bus_be` other than 4'hF completes at once, reads zero, changes no register and issues no downstream request.
- R12: Interrupt output k is the OR of `dev_irq[s]` over every slot s with s mod 4 = k. The slot is the device/function number shifted right by three.
- R13: An access to any offset other than the data port completes in the cycle it is presented, with `bus_ready` high in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Register access request, held until ready |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the access |
| bus_be | input | 4 | Byte enables; only 4'hF is a valid access |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access completes this cycle |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| cfg_valid | output | 1 | Downstream configuration request |
| cfg_write | output | 1 | Downstream request is a write |
| cfg_addr | output | 32 | Downstream configuration address |
| cfg_wdata | output | 32 | Downstream write data |
| cfg_ack | input | 1 | Downstream acknowledge |
| cfg_rdata | input | 32 | Downstream read data, valid with cfg_ack |
| cpu_addr | input | 32 | Processor address checked against the I/O window |
| io_hit | output | 1 | cpu_addr lies in the I/O window |
| dev_irq | input | 8 | Interrupt line per slot |
| irq_out | output | 4 | Merged interrupt outputs |

## Verification
Several properties are checked on every cycle:
- the downstream request stays asserted, with a stable address, until it is acknowledged;
- the bus never completes a data-port access while a request is outstanding;
- the I/O base never moves on a write with matching upper bits, and its middle bits stay zero;
- the configuration address only changes on a write to it;
- idle interrupt inputs give idle outputs.

Only the bench scenarios can show the rest:
- the masked read-back values;
- the reset contents of the header;
- the exact window edges;
- data returned through the data port;
- the effect of partial byte enables and unmapped writes.

// File: rtl/pcib_pkg.sv
package pcib_pkg;
    localparam int DW = 32;

    // byte offsets that software depends on
    localparam logic [11:0] OFS_CADDR = 12'h1C0;
    localparam logic [11:0] OFS_MBASE = 12'h1C4;
    localparam logic [11:0] OFS_IOBASE = 12'h1C8;
    localparam logic [11:0] OFS_DPORT = 12'h220;

    localparam logic [31:0] MBASE_MASK = 32'hFF00_0001;
    localparam logic [31:0] IOBASE_MASK = 32'hFFFC_0001;
    localparam logic [31:0] IOBASE_RST = 32'hFE24_0000;

    // command: wait cycle control; status: cap list, fast b2b, medium timing
    localparam logic [15:0] CMD_RST = 16'h0080;
    localparam logic [15:0] STS_RST = 16'h0290;

    typedef enum logic [1:0] {
        PORT_IDLE = 2'd0,
        PORT_BUSY = 2'd1,
        PORT_DONE = 2'd2
    } port_state_e;
endpackage

// File: rtl/pcib_cfg_hdr.sv
module pcib_cfg_hdr #(
    parameter int WORDS = 64,
    parameter logic [15:0] VENDOR_ID = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID = 16'h3C4D,
    localparam int IW = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] idx,
    input  logic [31:0]   wdata,
    output logic [31:0]   rdata
);
    import pcib_pkg::*;

    logic [31:0] mem_d [WORDS];
    logic [31:0] mem_q [WORDS];

    function automatic logic [31:0] init_word(int i);
        return (i == 1) ? {STS_RST, CMD_RST} : 32'h0;
    endfunction

    always_comb begin
        for (int i = 0; i < WORDS; i++) begin
            mem_d[i] = mem_q[i];
        end
        // word 0 carries constant identifiers and is never stored
        if (wr_en && idx != '0) begin
            mem_d[idx] = wdata;
        end
        mem_d[0] = {DEVICE_ID, VENDOR_ID};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= init_word(i);
            end
            mem_q[0] <= {DEVICE_ID, VENDOR_ID};
        end else begin
            for (int i = 0; i < WORDS; i++) begin
                mem_q[i] <= mem_d[i];
            end
        end
    end

    assign rdata = mem_q[idx];

    // R2: identifier word is never altered by traffic
    p_id_const_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && idx == '0 |=> mem_q[0] == {DEVICE_ID, VENDOR_ID});
endmodule

// File: rtl/pcib_iowin.sv
module pcib_iowin #(
    parameter logic [31:0] BASE_RST = 32'hFE24_0000,
    parameter int WIN_LOG2 = 18,
    localparam int UB = 32 - WIN_LOG2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    input  logic [31:0] cpu_addr,
    output logic [31:0] base,
    output logic        hit
);
    typedef struct packed {
        logic [UB-1:0] upper;
        logic          en;
    } iob_t;

    iob_t st_d, st_q;
    logic upper_same;

    always_comb begin
        st_d = st_q;
        upper_same = (wdata[31:WIN_LOG2] == st_q.upper);
        if (wr_en && !upper_same) begin
            st_d.upper = wdata[31:WIN_LOG2];
            st_d.en    = wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.upper <= BASE_RST[31:WIN_LOG2];
            st_q.en    <= BASE_RST[0];
        end else begin
            st_q <= st_d;
        end
    end

    assign base = {st_q.upper, {(WIN_LOG2-1){1'b0}}, st_q.en};
    assign hit  = (cpu_addr[31:WIN_LOG2] == st_q.upper);

    // R6: matching upper bits leave the whole register untouched
    p_iobase_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wdata[31:WIN_LOG2] == base[31:WIN_LOG2] |=> $stable(base));
    // R6: bits between bit 0 and the window boundary stay clear
    p_iobase_mid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        base[WIN_LOG2-1:1] == '0);
endmodule

// File: rtl/pcib_cfg_port.sv
module pcib_cfg_port (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        write,
    input  logic [31:0] wdata,
    input  logic [31:0] target,
    output logic        done,
    output logic [31:0] rdata,
    output logic        cfg_valid,
    output logic        cfg_write,
    output logic [31:0] cfg_addr,
    output logic [31:0] cfg_wdata,
    input  logic        cfg_ack,
    input  logic [31:0] cfg_rdata
);
    import pcib_pkg::*;

    typedef struct packed {
        port_state_e st;
        logic        wr;
        logic [31:0] addr;
        logic [31:0] wd;
        logic [31:0] rd;
    } port_t;

    port_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        unique case (s_q.st)
            PORT_IDLE: begin
                if (start) begin
                    s_d.st   = PORT_BUSY;
                    s_d.wr   = write;
                    s_d.addr = target;
                    s_d.wd   = wdata;
                end
            end
            PORT_BUSY: begin
                if (cfg_ack) begin
                    s_d.st = PORT_DONE;
                    s_d.rd = s_q.wr ? 32'h0 : cfg_rdata;
                end
            end
            PORT_DONE: s_d.st = PORT_IDLE;
            default:   s_d.st = PORT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: PORT_IDLE, wr: 1'b0, addr: 32'h0, wd: 32'h0, rd: 32'h0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done      = (s_q.st == PORT_DONE);
    assign rdata     = s_q.rd;
    assign cfg_valid = (s_q.st == PORT_BUSY);
    assign cfg_write = s_q.wr;
    assign cfg_addr  = s_q.addr;
    assign cfg_wdata = s_q.wd;

    // R8: request held with a steady address until acknowledged
    p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_ack |=> cfg_valid && $stable(cfg_addr));
    // R8: completion never overlaps an outstanding request
    p_no_early_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid |-> !done);
    // R9: direction is fixed for the life of a request
    p_dir_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid && !cfg_ack |=> $stable(cfg_write) && $stable(cfg_wdata));
endmodule

// File: rtl/pcib_irq_route.sv
module pcib_irq_route #(
    parameter int NUM_SLOTS = 8,
    parameter int NUM_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] dev_irq,
    output logic [NUM_LINES-1:0] irq_out
);
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        logic [NUM_SLOTS-1:0] sel;
        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
            assign sel[s] = ((s % NUM_LINES) == k) ? dev_irq[s] : 1'b0;
        end
        assign irq_out[k] = |sel;
    end

    // R12: quiet slots give quiet outputs
    p_irq_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        dev_irq == '0 |-> irq_out == '0);
    // R12: no output without some slot asserting
    p_irq_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out != '0 |-> dev_irq != '0);
endmodule

// File: rtl/pcib_regs.sv
module pcib_regs #(
    parameter int AW = 12,
    parameter int HDR_WORDS = 64,
    parameter int NUM_SLOTS = 8,
    parameter int NUM_LINES = 4,
    parameter logic [15:0] VENDOR_ID = 16'h1A2B,
    parameter logic [15:0] DEVICE_ID = 16'h3C4D,
    localparam int HIW = $clog2(HDR_WORDS),
    localparam int HDR_BYTES = HDR_WORDS * 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [AW-1:0]        bus_addr,
    input  logic [3:0]           bus_be,
    input  logic [31:0]          bus_wdata,
    output logic                 bus_ready,
    output logic [31:0]          bus_rdata,
    output logic                 cfg_valid,
    output logic                 cfg_write,
    output logic [31:0]          cfg_addr,
    output logic [31:0]          cfg_wdata,
    input  logic                 cfg_ack,
    input  logic [31:0]          cfg_rdata,
    input  logic [31:0]          cpu_addr,
    output logic                 io_hit,
    input  logic [NUM_SLOTS-1:0] dev_irq,
    output logic [NUM_LINES-1:0] irq_out
);
    import pcib_pkg::*;

    typedef struct packed {
        logic [31:0] caddr;
        logic [31:0] mbase;
    } regs_t;

    regs_t r_d, r_q;

    logic        full, sel_hdr, sel_caddr, sel_mbase, sel_iob, sel_port;
    logic        wr_local, port_start, port_done;
    logic [31:0] hdr_rdata, port_rdata, iob_val;

    always_comb begin
        full      = (bus_be == 4'hF);
        sel_hdr   = (int'(bus_addr) < HDR_BYTES);
        sel_caddr = (bus_addr == OFS_CADDR[AW-1:0]);
        sel_mbase = (bus_addr == OFS_MBASE[AW-1:0]);
        sel_iob   = (bus_addr == OFS_IOBASE[AW-1:0]);
        sel_port  = (bus_addr == OFS_DPORT[AW-1:0]);

        port_start = bus_valid && full && sel_port;
        wr_local   = bus_valid && bus_write && full && !sel_port;

        r_d = r_q;
        if (wr_local && sel_caddr) r_d.caddr = bus_wdata;
        if (wr_local && sel_mbase) r_d.mbase = bus_wdata & MBASE_MASK;

        bus_ready = (bus_valid && !port_start) || port_done;

        bus_rdata = 32'h0;
        if (full) begin
            if (sel_port)       bus_rdata = port_rdata;
            else if (sel_hdr)   bus_rdata = hdr_rdata;
            else if (sel_caddr) bus_rdata = r_q.caddr;
            else if (sel_mbase) bus_rdata = r_q.mbase;
            else if (sel_iob)   bus_rdata = iob_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    pcib_cfg_hdr #(
        .WORDS(HDR_WORDS), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID)
    ) u_hdr (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_local && sel_hdr),
        .idx(bus_addr[HIW+1:2]),
        .wdata(bus_wdata),
        .rdata(hdr_rdata)
    );

    pcib_iowin #(.BASE_RST(IOBASE_RST), .WIN_LOG2(18)) u_iowin (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_local && sel_iob),
        .wdata(bus_wdata),
        .cpu_addr(cpu_addr),
        .base(iob_val),
        .hit(io_hit)
    );

    pcib_cfg_port u_port (
        .clk(clk), .rst_n(rst_n),
        .start(port_start),
        .write(bus_write),
        .wdata(bus_wdata),
        .target(r_q.caddr),
        .done(port_done),
        .rdata(port_rdata),
        .cfg_valid(cfg_valid),
        .cfg_write(cfg_write),
        .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata),
        .cfg_ack(cfg_ack),
        .cfg_rdata(cfg_rdata)
    );

    pcib_irq_route #(.NUM_SLOTS(NUM_SLOTS), .NUM_LINES(NUM_LINES)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .dev_irq(dev_irq),
        .irq_out(irq_out)
    );

    // R4: address register only moves on a full write to its offset
    p_caddr_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && bus_write && bus_be == 4'hF && bus_addr == OFS_CADDR[AW-1:0])
        |=> $stable(r_q.caddr));
    // R11: partial accesses never reach downstream
    p_partial_no_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_be != 4'hF && !cfg_valid |=> !cfg_valid);
    // R13: a local access completes in the cycle it is presented
    p_local_ready_r13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_addr != OFS_DPORT[AW-1:0] && !cfg_valid |-> bus_ready);
endmodule

// File: tb/tb_pcib_regs.sv
module tb_pcib_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [3:0]  bus_be = 4'hF;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic        cfg_valid, cfg_write;
    logic [31:0] cfg_addr, cfg_wdata;
    logic        cfg_ack = 1'b0;
    logic [31:0] cfg_rdata = '0;
    logic [31:0] cpu_addr = '0;
    logic        io_hit;
    logic [7:0]  dev_irq = '0;
    logic [3:0]  irq_out;

    int checks = 0, errors = 0;
    int req_seen = 0;
    logic        last_wr;
    logic [31:0] last_addr, last_wdata;

    always #5 clk = ~clk;

    pcib_regs dut (.*);

    // downstream responder: acknowledges on the third cycle of a request
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            cfg_ack = 1'b0;
            if (cfg_valid) begin
                cnt++;
                if (cnt == 3) begin
                    cfg_ack    = 1'b1;
                    cfg_rdata  = cfg_addr ^ 32'hA5A5_A5A5;
                    last_wr    = cfg_write;
                    last_addr  = cfg_addr;
                    last_wdata = cfg_wdata;
                    req_seen++;
                    cnt = 0;
                end
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [11:0] a, input logic [3:0] be,
                        input logic [31:0] wd, output logic [31:0] rd, output int waits);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_be = be; bus_wdata = wd;
        waits = 0;
        forever begin
            #2;
            if (bus_ready) begin
                rd = bus_rdata;
                break;
            end
            waits++;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; bus_be = 4'hF;
    endtask

    typedef struct packed {
        logic        rd;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h1C0, 32'hDEAD_BEEF, 32'h0, 8'd4},           // R4
        '{1'b1, 12'h1C0, 32'h0, 32'hDEAD_BEEF, 8'd4},
        '{1'b0, 12'h1C4, 32'hFFFF_FFFF, 32'h0, 8'd5},           // R5
        '{1'b1, 12'h1C4, 32'h0, 32'hFF00_0001, 8'd5},
        '{1'b0, 12'h1C8, 32'h1234_5677, 32'h0, 8'd6},           // R6
        '{1'b1, 12'h1C8, 32'h0, 32'h1234_0001, 8'd6},
        '{1'b0, 12'h1C8, 32'h1237_0000, 32'h0, 8'd6},           // same upper bits
        '{1'b1, 12'h1C8, 32'h0, 32'h1234_0001, 8'd6},
        '{1'b0, 12'h010, 32'hCAFE_F00D, 32'h0, 8'd1},           // R1
        '{1'b1, 12'h010, 32'h0, 32'hCAFE_F00D, 8'd1},
        '{1'b0, 12'h0FC, 32'h0102_0304, 32'h0, 8'd1},
        '{1'b1, 12'h0FC, 32'h0, 32'h0102_0304, 8'd1},
        '{1'b0, 12'h000, 32'hFFFF_FFFF, 32'h0, 8'd2},           // R2
        '{1'b1, 12'h000, 32'h0, 32'h3C4D_1A2B, 8'd2},
        '{1'b0, 12'h100, 32'h5555_5555, 32'h0, 8'd10},          // R10
        '{1'b1, 12'h100, 32'h0, 32'h0, 8'd10},
        '{1'b0, 12'h1CC, 32'h7777_7777, 32'h0, 8'd10},
        '{1'b1, 12'h1CC, 32'h0, 32'h0, 8'd10},
        '{1'b1, 12'h1C0, 32'h0, 32'hDEAD_BEEF, 8'd10}
    };

    initial begin
        logic [31:0] rd;
        int waits;
        int seen0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        xfer(1'b0, 12'h004, 4'hF, 32'h0, rd, waits);
        check("R3 cmd/status reset", rd, 32'h0290_0080);
        xfer(1'b0, 12'h008, 4'hF, 32'h0, rd, waits);
        check("R3 other header zero", rd, 32'h0);
        xfer(1'b0, 12'h1C8, 4'hF, 32'h0, rd, waits);
        check("R6 io base reset", rd, 32'hFE24_0000);
        xfer(1'b0, 12'h1C0, 4'hF, 32'h0, rd, waits);
        check("R4 caddr reset", rd, 32'h0);
        check("R13 local read zero wait", waits, 0);

        // R7 window edges at reset base
        cpu_addr = 32'hFE24_0000; #1 check("R7 window start", io_hit, 1'b1);
        cpu_addr = 32'hFE27_FFFC; #1 check("R7 window end", io_hit, 1'b1);
        cpu_addr = 32'hFE28_0000; #1 check("R7 above window", io_hit, 1'b0);
        cpu_addr = 32'hFE23_FFFC; #1 check("R7 below window", io_hit, 1'b0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            xfer(!VECS[i].rd, VECS[i].addr, 4'hF, VECS[i].data, rd, waits);
            if (VECS[i].rd) check($sformatf("R%0d vector %0d", VECS[i].req, i), rd, VECS[i].exp);
            else check("R13 write zero wait", waits, 0);
        end

        // R7 after relocation
        cpu_addr = 32'h1234_0010; #1 check("R7 moved window", io_hit, 1'b1);
        cpu_addr = 32'hFE24_0000; #1 check("R7 old window gone", io_hit, 1'b0);

        // R11 partial byte enables
        seen0 = req_seen;
        xfer(1'b1, 12'h1C0, 4'h3, 32'h1111_1111, rd, waits);
        xfer(1'b0, 12'h1C0, 4'hF, 32'h0, rd, waits);
        check("R11 partial write ignored", rd, 32'hDEAD_BEEF);
        xfer(1'b0, 12'h1C0, 4'h7, 32'h0, rd, waits);
        check("R11 partial read zero", rd, 32'h0);
        xfer(1'b0, 12'h220, 4'h1, 32'h0, rd, waits);
        check("R11 partial port read zero", rd, 32'h0);
        check("R11 partial port no wait", waits, 0);
        repeat (4) @(negedge clk);
        check("R11 no downstream", req_seen, seen0);

        // R8 data port read
        xfer(1'b0, 12'h220, 4'hF, 32'h0, rd, waits);
        check("R8 read data", rd, 32'hDEAD_BEEF ^ 32'hA5A5_A5A5);
        check("R8 read addr", last_addr, 32'hDEAD_BEEF);
        check("R8 read dir", last_wr, 1'b0);
        check("R8 waits", waits, 4);
        check("R8 one request", req_seen, seen0 + 1);

        // R9 data port write to a new target
        xfer(1'b1, 12'h1C0, 4'hF, 32'h8000_0810, rd, waits);
        xfer(1'b1, 12'h220, 4'hF, 32'h1122_3344, rd, waits);
        check("R9 write dir", last_wr, 1'b1);
        check("R9 write addr", last_addr, 32'h8000_0810);
        check("R9 write data", last_wdata, 32'h1122_3344);

        // R12 interrupt routing
        dev_irq = 8'b0000_0100; #1 check("R12 slot2", irq_out, 4'b0100);
        dev_irq = 8'b1000_0001; #1 check("R12 slot7+0", irq_out, 4'b1001);
        dev_irq = 8'b0010_0000; #1 check("R12 slot5", irq_out, 4'b0010);
        dev_irq = 8'b0000_0000; #1 check("R12 idle", irq_out, 4'b0000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule